// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block turns a six-byte window, read from byte-addressed memory starting at the current program counter, into the fields of one instruction. The opcode is taken from the first byte and decides everything else: how many bytes the instruction occupies, whether a register-specifier byte follows, and where a 32-bit little-endian constant sits. The block also reports whether the encoding is legal, whether the instruction is the stop instruction, and the address of the next sequential instruction.

Decoding is purely combinational. A small registered stepper holds the program counter. It loads the next-sequential address on every clock and freezes when the decoded instruction is a stop or an illegal encoding. The surrounding fetch logic presents the memory bytes at the counter's address as the window, so the block walks through straight-line code on its own. An elaboration option lets illegal encodings be stepped over instead of freezing the counter.

Top module: `insn_fetch_decoder`

## Requirements
- R1: The window carries the byte at the program counter in bits 7:0 and the byte at counter+k in bits 8k+7:8k. The opcode output is bits 7:4 of that first byte and the function output is bits 3:0.
- R2: For opcodes 2, 3, 4, 5, 6, 10 and 11 the second byte is a register byte: the first register output is its bits 7:4 and the second is its bits 3:0. For every other opcode both register outputs read 8, the code for "no register".
- R3: The constant output is bytes 2..5 of the window, least significant byte first, for opcodes 3, 4 and 5. It is bytes 1..4, least significant first, for opcodes 7 and 8. For all other opcodes it is zero.
- R4: The length output is 1 for opcodes 0, 1 and 9; 2 for opcodes 2, 6, 10 and 11; 5 for opcodes 7 and 8; and 6 for opcodes 3, 4 and 5.
- R5: The next-address output equals the program counter plus the length, with 32-bit wrap-around.
- R6: The error output is high, and the valid output low, when the opcode is 12 to 15, when opcode 6 has a function above 3, when opcode 7 has a function above 6, or when any other opcode has a nonzero function. An unknown opcode reports length 1, register codes 8 and a zero constant.
- R7: The stop output is high only for the byte 0x10 (opcode 1, function 0). It is never high together with the error output.
- R8: With the default option, on each rising clock the program counter takes the next-address value unless the current instruction is a stop or an error, in which case it holds.
- R9: While the active-low reset is asserted, the program counter equals the reset address parameter (default 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win | input | 48 | Instruction bytes at pc, first byte in bits 7:0 |
| pc | output | 32 | Current program counter |
| icode | output | 4 | Opcode nibble |
| ifun | output | 4 | Function nibble |
| ra | output | 4 | First register specifier (8 = none) |
| rb | output | 4 | Second register specifier (8 = none) |
| val_c | output | 32 | Constant or absolute destination |
| ilen | output | 3 | Instruction length in bytes |
| next_pc | output | 32 | pc + ilen |
| insn_ok | output | 1 | Encoding is legal |
| bad_insn | output | 1 | Encoding is illegal |
| is_halt | output | 1 | Legal stop instruction |

## Verification
Two functions can fall in the same cycle: stop detection and illegal-encoding detection. Both look at the same first byte, and both freeze the counter. The bench provokes the overlap with a stop opcode that carries a nonzero function (0x11) and with the return opcode carrying a function (0x91). It checks that only the error output rises, that the counter holds, and that a clean 0x10 gives the stop flag alone. The other collision is wrap-around of the next address. It is provoked by a second instance whose reset address is 0xFFFFFFFF, and is judged by the counter landing on 1 after one clock.

// File: rtl/ifd_pkg.sv
package ifd_pkg;

   localparam int CONST_BYTES = 4;
   localparam logic [3:0] NO_REG = 4'h8;

   localparam logic [3:0] OPC_NOP   = 4'h0;
   localparam logic [3:0] OPC_STOP  = 4'h1;
   localparam logic [3:0] OPC_RR    = 4'h2;
   localparam logic [3:0] OPC_IR    = 4'h3;
   localparam logic [3:0] OPC_RM    = 4'h4;
   localparam logic [3:0] OPC_MR    = 4'h5;
   localparam logic [3:0] OPC_ALU   = 4'h6;
   localparam logic [3:0] OPC_JMP   = 4'h7;
   localparam logic [3:0] OPC_CALL  = 4'h8;
   localparam logic [3:0] OPC_RET   = 4'h9;
   localparam logic [3:0] OPC_PUSH  = 4'hA;
   localparam logic [3:0] OPC_POP   = 4'hB;

   localparam logic [3:0] ALU_FUN_MAX = 4'h3;
   localparam logic [3:0] JMP_FUN_MAX = 4'h6;

   typedef struct packed {
      logic       has_regs;
      logic       has_const;
      logic       const_at2;
      logic [2:0] len;
   } fmt_t;

endpackage

// File: rtl/ifd_classify.sv
module ifd_classify
   import ifd_pkg::*;
(
   input  logic [3:0] icode,
   input  logic [3:0] ifun,
   output fmt_t       fmt,
   output logic       bad,
   output logic       halt
);

   always_comb begin
      fmt = '{has_regs: 1'b0, has_const: 1'b0, const_at2: 1'b0, len: 3'd1};
      bad = (ifun != 4'h0);
      unique case (icode)
         OPC_NOP, OPC_STOP, OPC_RET: ;
         OPC_RR, OPC_PUSH, OPC_POP: begin
            fmt.has_regs = 1'b1;
            fmt.len      = 3'd2;
         end
         OPC_IR, OPC_RM, OPC_MR: begin
            fmt.has_regs  = 1'b1;
            fmt.has_const = 1'b1;
            fmt.const_at2 = 1'b1;
            fmt.len       = 3'd6;
         end
         OPC_ALU: begin
            fmt.has_regs = 1'b1;
            fmt.len      = 3'd2;
            bad          = (ifun > ALU_FUN_MAX);
         end
         OPC_JMP: begin
            fmt.has_const = 1'b1;
            fmt.len       = 3'd5;
            bad           = (ifun > JMP_FUN_MAX);
         end
         OPC_CALL: begin
            fmt.has_const = 1'b1;
            fmt.len       = 3'd5;
         end
         default: bad = 1'b1;
      endcase
      halt = (icode == OPC_STOP) && !bad;
   end

endmodule

// File: rtl/ifd_extract.sv
module ifd_extract
   import ifd_pkg::*;
#(
   parameter int WIN_BYTES = 6,
   localparam int WIN_W = WIN_BYTES * 8,
   localparam int C_W   = CONST_BYTES * 8
) (
   input  logic [WIN_W-1:0] win,
   input  fmt_t             fmt,
   output logic [3:0]       ra,
   output logic [3:0]       rb,
   output logic [C_W-1:0]   val_c
);

   assign ra = fmt.has_regs ? win[15:12] : NO_REG;
   assign rb = fmt.has_regs ? win[11:8]  : NO_REG;

   for (genvar k = 0; k < CONST_BYTES; k++) begin : g_cbyte
      logic [7:0] near_b, far_b;
      assign near_b = win[(k+1)*8 +: 8];
      assign far_b  = win[(k+2)*8 +: 8];
      assign val_c[k*8 +: 8] = !fmt.has_const ? 8'h00 :
                               (fmt.const_at2 ? far_b : near_b);
   end

   if (WIN_BYTES > CONST_BYTES + 2) begin : g_spare
      logic spare_unused;
      assign spare_unused = ^win[WIN_W-1:(CONST_BYTES+2)*8];
   end

endmodule

// File: rtl/ifd_pc_step.sv
module ifd_pc_step #(
   parameter int             ADDR_W   = 32,
   parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        len,
   input  logic              hold,
   output logic [ADDR_W-1:0] pc,
   output logic [ADDR_W-1:0] next_pc
);

   assign next_pc = pc + {{(ADDR_W-3){1'b0}}, len};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pc <= RESET_PC;
      else if (!hold)
         pc <= next_pc;
   end

endmodule

// File: rtl/insn_fetch_decoder.sv
module insn_fetch_decoder
   import ifd_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int WIN_BYTES   = 6,
   parameter logic [ADDR_W-1:0] RESET_PC = '0,
   parameter bit STOP_ON_BAD = 1'b1,
   localparam int WIN_W = WIN_BYTES * 8,
   localparam int C_W   = CONST_BYTES * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WIN_W-1:0]  win,
   output logic [ADDR_W-1:0] pc,
   output logic [3:0]        icode,
   output logic [3:0]        ifun,
   output logic [3:0]        ra,
   output logic [3:0]        rb,
   output logic [C_W-1:0]    val_c,
   output logic [2:0]        ilen,
   output logic [ADDR_W-1:0] next_pc,
   output logic              insn_ok,
   output logic              bad_insn,
   output logic              is_halt
);

   if (WIN_BYTES < CONST_BYTES + 2) begin : g_chk_win
      $error("insn_fetch_decoder: window narrower than longest instruction");
   end
   if (ADDR_W < 8) begin : g_chk_addr
      $error("insn_fetch_decoder: address width too small");
   end

   fmt_t fmt;
   logic hold;

   assign icode = win[7:4];
   assign ifun  = win[3:0];

   ifd_classify u_cls (
      .icode (icode),
      .ifun  (ifun),
      .fmt   (fmt),
      .bad   (bad_insn),
      .halt  (is_halt)
   );

   ifd_extract #(.WIN_BYTES(WIN_BYTES)) u_ext (
      .win   (win),
      .fmt   (fmt),
      .ra    (ra),
      .rb    (rb),
      .val_c (val_c)
   );

   assign ilen    = fmt.len;
   assign insn_ok = !bad_insn;

   if (STOP_ON_BAD) begin : g_hold_bad
      assign hold = is_halt | bad_insn;
   end else begin : g_skip_bad
      assign hold = is_halt;
   end

   ifd_pc_step #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_step (
      .clk     (clk),
      .rst_n   (rst_n),
      .len     (ilen),
      .hold    (hold),
      .pc      (pc),
      .next_pc (next_pc)
   );

endmodule

// File: rtl/insn_fetch_decoder_chk.sv
module insn_fetch_decoder_chk #(
   parameter int ADDR_W      = 32,
   parameter bit STOP_ON_BAD = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] pc,
   input logic [3:0]        icode,
   input logic [3:0]        ra,
   input logic [3:0]        rb,
   input logic [31:0]       val_c,
   input logic [2:0]        ilen,
   input logic [ADDR_W-1:0] next_pc,
   input logic              bad_insn,
   input logic              is_halt
);

   p_len_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ilen == 3'd1) || (ilen == 3'd2) || (ilen == 3'd5) || (ilen == 3'd6));

   p_halt_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      is_halt |-> !bad_insn);

   p_next_sum_r5: assert property (@(posedge clk) disable iff (!rst_n)
      next_pc == pc + {{(ADDR_W-3){1'b0}}, ilen});

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (is_halt || (bad_insn && STOP_ON_BAD)) |=> $stable(pc));

   p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(is_halt || bad_insn) |=> (pc == $past(next_pc)));

   p_noreg_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (icode == 4'h0 || icode == 4'h1 || icode == 4'h7 || icode == 4'h8 || icode == 4'h9)
      |-> (ra == 4'h8 && rb == 4'h8));

   p_noconst_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ilen == 3'd1 || ilen == 3'd2) |-> (val_c == 32'h0));

endmodule

bind insn_fetch_decoder insn_fetch_decoder_chk #(
   .ADDR_W(ADDR_W), .STOP_ON_BAD(STOP_ON_BAD)
) u_chk (
   .clk(clk), .rst_n(rst_n), .pc(pc), .icode(icode), .ra(ra), .rb(rb),
   .val_c(val_c), .ilen(ilen), .next_pc(next_pc), .bad_insn(bad_insn),
   .is_halt(is_halt)
);

// File: tb/insn_fetch_decoder_bench.sv
`timescale 1ns/1ps
module insn_fetch_decoder_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [7:0]  mem [64];
   logic [47:0] win;
   logic [31:0] pc, next_pc, val_c;
   logic [3:0]  icode, ifun, ra, rb;
   logic [2:0]  ilen;
   logic        insn_ok, bad_insn, is_halt;

   logic [31:0] w_pc, w_next, w_c;
   logic [3:0]  w_ic, w_if, w_ra, w_rb;
   logic [2:0]  w_len;
   logic        w_ok, w_bad, w_halt;

   int n_chk = 0;
   int n_err = 0;
   bit mon_en = 1'b0;
   bit done = 1'b0;
   logic [31:0] exp_pc;

   always_comb begin
      for (int k = 0; k < 6; k++) win[k*8 +: 8] = mem[(pc + k) & 32'd63];
   end

   insn_fetch_decoder u_insn_fetch_decoder (
      .clk(clk), .rst_n(rst_n), .win(win), .pc(pc), .icode(icode), .ifun(ifun),
      .ra(ra), .rb(rb), .val_c(val_c), .ilen(ilen), .next_pc(next_pc),
      .insn_ok(insn_ok), .bad_insn(bad_insn), .is_halt(is_halt)
   );

   insn_fetch_decoder #(.RESET_PC(32'hFFFF_FFFF)) u_insn_fetch_decoder_wrap (
      .clk(clk), .rst_n(rst_n), .win(48'h0000_0000_4320), .pc(w_pc), .icode(w_ic),
      .ifun(w_if), .ra(w_ra), .rb(w_rb), .val_c(w_c), .ilen(w_len), .next_pc(w_next),
      .insn_ok(w_ok), .bad_insn(w_bad), .is_halt(w_halt)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Behavioural reference: decode the bytes at exp_pc, compare, then advance.
   always @(negedge clk) begin
      if (mon_en) begin
         logic [7:0] b [6];
         int op, fn, len, e_ra, e_rb;
         logic [31:0] c;
         bit bad, halt;
         for (int k = 0; k < 6; k++) b[k] = mem[(exp_pc + k) & 32'd63];
         op = b[0] >> 4; fn = b[0] & 15;
         e_ra = 8; e_rb = 8; c = 0; len = 1; bad = (fn != 0);
         if (op == 0 || op == 1 || op == 9) len = 1;
         else if (op == 2 || op == 6 || op == 10 || op == 11) begin
            len = 2; e_ra = b[1] >> 4; e_rb = b[1] & 15;
            if (op == 6) bad = (fn > 3);
         end else if (op >= 3 && op <= 5) begin
            len = 6; e_ra = b[1] >> 4; e_rb = b[1] & 15;
            c = {b[5], b[4], b[3], b[2]};
         end else if (op == 7 || op == 8) begin
            len = 5; c = {b[4], b[3], b[2], b[1]};
            if (op == 7) bad = (fn > 6);
         end else begin
            bad = 1;
         end
         halt = (b[0] == 8'h10);
         check("R9/R8 pc", pc, exp_pc);
         check("R1 opcode", {28'h0, icode}, op);
         check("R1 function", {28'h0, ifun}, fn);
         check("R2 reg A", {28'h0, ra}, e_ra);
         check("R2 reg B", {28'h0, rb}, e_rb);
         check("R3 constant", val_c, c);
         check("R4 length", {29'h0, ilen}, len);
         check("R5 next address", next_pc, exp_pc + len);
         check("R6 error", {31'h0, bad_insn}, bad);
         check("R6 valid", {31'h0, insn_ok}, !bad);
         check("R7 stop", {31'h0, is_halt}, halt);
         if (!(bad || halt)) exp_pc = exp_pc + len;
      end
   end

   task automatic load_prog();
      byte unsigned p [39] = '{
         8'h30, 8'h82, 8'hcd, 8'hab, 8'h00, 8'h00,   // 0x00 const load, 6 bytes
         8'h20, 8'h43,                               // 0x06 reg move
         8'h50, 8'h15, 8'hf4, 8'hff, 8'hff, 8'hff,   // 0x08 mem read
         8'h40, 8'h64, 8'h1c, 8'h04, 8'h00, 8'h00,   // 0x0E mem write
         8'h63, 8'h01,                               // 0x14 alu max function
         8'h76, 8'h28, 8'h00, 8'h00, 8'h00,          // 0x16 jump max function
         8'h80, 8'h28, 8'h00, 8'h00, 8'h00,          // 0x1B call
         8'ha0, 8'h28, 8'hb0, 8'h08,                 // 0x20 push, pop
         8'h90, 8'h00, 8'h11 };                      // 0x24 ret, nop, stop+fun
      for (int i = 0; i < 64; i++) mem[i] = (i < 39) ? p[i] : 8'h00;
   endtask

   task automatic run_phase(input int cycles);
      #1 rst_n = 1'b0;
      exp_pc = 32'h0;
      @(negedge clk);
      check("R9 reset pc", pc, 32'h0);
      rst_n = 1'b1;
      mon_en = 1'b1;
      repeat (cycles) @(negedge clk);
      mon_en = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      #200000;
      n_err++;
      $display("FAIL R8 watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      logic [7:0] bad_codes [5] = '{8'hC0, 8'h66, 8'h77, 8'h91, 8'hF0};
      load_prog();
      repeat (3) @(negedge clk);
      // R9 and R5: wrap instance held in reset
      check("R9 wrap reset pc", w_pc, 32'hFFFF_FFFF);
      check("R5 wrap next address", w_next, 32'h0000_0001);
      check("R4 wrap length", {29'h0, w_len}, 32'd2);
      rst_n = 1'b1;
      @(negedge clk);
      check("R5 wrap pc after step", w_pc, 32'h0000_0001);
      // R8: program with stop+function at 0x26 freezes there (error wins, R7)
      run_phase(16);
      check("R8 frozen at illegal stop", pc, 32'h26);
      // R7: clean stop byte
      mem[38] = 8'h10;
      run_phase(16);
      check("R7 frozen at stop", pc, 32'h26);
      // R6: illegal encodings at 0x06
      foreach (bad_codes[i]) begin
         load_prog();
         mem[6] = bad_codes[i];
         run_phase(5);
         check("R6 frozen at illegal", pc, 32'h06);
      end
      finish_run();
   end

endmodule